// File: doc/BRIEF.md
# Word-Addressed Load/Store Unit

This unit carries out the memory operations of a small processor core whose data memory is indexed by word. Each request carries a two-bit operation code, a base register value, a sign-extended immediate, an offset register value, store data and a destination tag. The unit forms the effective word address as the base plus either the immediate or the offset register. It then performs one single-cycle access to an internal data memory.

A load returns its memory word on the cycle after it is accepted, together with the destination tag and a result-valid flag. That result stays on the output until the consumer takes it with `out_ready`. While a result is pending and not being taken, the unit stops accepting requests. A store updates memory and produces no result.

Top module: `lsu_mem_unit`

## Requirements
- R1: Operation code 2'b00 (load, immediate offset) returns the memory word at base + immediate.
- R2: Operation code 2'b01 (load, register offset) returns the memory word at base + offset register.
- R3: Operation code 2'b10 (store, immediate offset) writes the store data to the memory word at base + immediate.
- R4: Operation code 2'b11 (store, register offset) writes the store data to the memory word at base + offset register.
- R5: The word address is the low 10 bits of the 32-bit sum, with no byte scaling. Sums that differ only above bit 9 reach the same word.
- R6: The 16-bit immediate is sign-extended to 32 bits before the add, so a negative immediate addresses below the base.
- R7: A load accepted at a clock edge raises `out_valid` at that edge's next cycle, and carries the request's tag on `out_tag`.
- R8: An accepted store is never followed by `out_valid` in the next cycle.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low. No request is accepted, and `out_data` and `out_tag` hold steady.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_op | input | 2 | Bit 1: store, bit 0: register offset |
| in_base | input | 32 | Base register value |
| in_imm | input | 16 | Signed immediate offset |
| in_offr | input | 32 | Offset register value |
| in_sdata | input | 32 | Store data |
| in_tag | input | 5 | Destination register tag |
| out_valid | output | 1 | Load result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Loaded word |
| out_tag | output | 5 | Tag of the loaded word |

## Verification
The hardest case to reach from the ports is a request that is offered while a load result is stalled. That request must be refused. This matters most for a store, because an accepted store changes memory without any visible result. The bench holds `out_ready` low after a load and keeps a store request asserted for several cycles, checking that the stalled result stays steady. It then releases the stall and reloads the targeted word to show that memory was not touched. Address aliasing and negative immediates are reached by pairing a store in one addressing mode with a load in the other.

// File: rtl/lsu_pkg.sv
// Package: shared operation encoding for the load/store unit.
// Assumes a two-bit code where bit 1 selects store and bit 0 selects
// the register offset instead of the immediate.
package lsu_pkg;
    typedef enum logic [1:0] {
        OP_LD_IMM = 2'b00,
        OP_LD_REG = 2'b01,
        OP_ST_IMM = 2'b10,
        OP_ST_REG = 2'b11
    } lsu_op_e;

    localparam int OP_STORE_BIT = 1;
    localparam int OP_REGOFF_BIT = 0;
endpackage

// File: rtl/lsu_agen.sv
// Module: effective word address generator.
// Adds the base to either the sign-extended immediate or the offset
// register, and keeps the low ADDR_W bits as the word index.
// Assumes DATA_W > ADDR_W and DATA_W >= IMM_W.
module lsu_agen #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] offr,
    output logic [ADDR_W-1:0] addr
);
    import lsu_pkg::*;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] sum;
    logic              unused_hi;

    // Sign-extend the immediate and pick the offset source.
    always_comb begin
        imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        offset  = op[OP_REGOFF_BIT] ? offr : imm_ext;
        sum     = base + offset;
    end

    assign addr      = sum[ADDR_W-1:0];
    assign unused_hi = ^sum[DATA_W-1:ADDR_W];
endmodule

// File: rtl/lsu_dmem.sv
// Module: word-wide data memory with one access port.
// A write or a read happens at the clock edge. Read data is registered
// and holds its value until the next read. Contents are not reset.
module lsu_dmem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    // Write the array on a store access.
    always_ff @(posedge clk) begin
        if (wr_en) store_q[addr] <= wdata;
    end

    // Capture the read word on a load access.
    always_ff @(posedge clk) begin
        if (rd_en) rdata <= store_q[addr];
    end
endmodule

// File: rtl/lsu_result.sv
// Module: result holding stage for load data.
// It raises valid on the cycle after a load is accepted and keeps it
// until the consumer takes the result. The tag is latched with the load.
// Assumes no new load is accepted while a result is pending and not taken.
module lsu_result #(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_fire,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             take,
    output logic             valid,
    output logic [TAG_W-1:0] tag_out
);
    // Track whether a load result is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)         valid <= 1'b0;
        else if (load_fire) valid <= 1'b1;
        else if (take)      valid <= 1'b0;
    end

    // Latch the destination tag of each accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)         tag_out <= '0;
        else if (load_fire) tag_out <= tag_in;
    end
endmodule

// File: rtl/lsu_mem_unit.sv
// Module: load/store unit top.
// It accepts one request per cycle through a ready/valid handshake,
// computes the word address, and performs the memory access. Load
// results come back one cycle later through a valid/ready output.
// Stores produce no result. Assumes whole-word accesses only.
module lsu_mem_unit #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int TAG_W  = 5,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_base,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [DATA_W-1:0] in_offr,
    input  logic [DATA_W-1:0] in_sdata,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag
);
    import lsu_pkg::*;

    localparam int ADDR_W = $clog2(DEPTH);

    logic              fire;
    logic              is_store;
    logic [ADDR_W-1:0] word_addr;

    // Accept when no result is stuck on the output.
    always_comb begin
        in_ready = !out_valid || out_ready;
        fire     = in_valid && in_ready;
        is_store = in_op[OP_STORE_BIT];
    end

    lsu_agen #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .ADDR_W (ADDR_W)
    ) u_agen (
        .op   (in_op),
        .base (in_base),
        .imm  (in_imm),
        .offr (in_offr),
        .addr (word_addr)
    );

    lsu_dmem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_dmem (
        .clk   (clk),
        .wr_en (fire && is_store),
        .rd_en (fire && !is_store),
        .addr  (word_addr),
        .wdata (in_sdata),
        .rdata (out_data)
    );

    lsu_result #(
        .TAG_W (TAG_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_fire (fire && !is_store),
        .tag_in    (in_tag),
        .take      (out_ready),
        .valid     (out_valid),
        .tag_out   (out_tag)
    );
endmodule

// File: rtl/lsu_mem_unit_chk.sv
// Module: assertion checker for the load/store unit, bound to the top.
// Watches only the top-level handshake and result ports.
module lsu_mem_unit_chk #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_op,
    input logic [TAG_W-1:0]  in_tag,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [TAG_W-1:0]  out_tag
);
    AST_LOAD_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_op[1]) |=> (out_valid && out_tag == $past(in_tag))); // R7

    AST_STORE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op[1]) |=> !out_valid); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag))); // R9

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R9

    AST_VALID_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && !in_op[1])); // R7
endmodule

bind lsu_mem_unit lsu_mem_unit_chk #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
) u_chk (.*);

// File: tb/tb_lsu_mem_unit.sv
// Bench: scoreboard for the load/store unit. A driver task keeps a
// reference memory and queues the expected load results. A monitor
// pops them as results are taken at the output.
module tb_lsu_mem_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_op = '0;
    logic [DW-1:0] in_base = '0;
    logic [15:0]   in_imm = '0;
    logic [DW-1:0] in_offr = '0;
    logic [DW-1:0] in_sdata = '0;
    logic [TW-1:0] in_tag = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [TW-1:0] out_tag;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] ref_mem [1024];
    logic [DW-1:0] exp_data_q [$];
    logic [TW-1:0] exp_tag_q [$];
    string         exp_req_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_mem_unit dut (.*);

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: called at a falling edge and returns at a falling edge.
    task automatic issue(input logic [1:0] op, input logic [DW-1:0] base,
                         input logic [15:0] imm, input logic [DW-1:0] offr,
                         input logic [DW-1:0] sdata, input logic [TW-1:0] tag,
                         input string req);
        logic [DW-1:0] sum;
        logic [9:0]    a;
        sum = base + (op[0] ? offr : {{16{imm[15]}}, imm});
        a = sum[9:0];
        in_op = op; in_base = base; in_imm = imm; in_offr = offr;
        in_sdata = sdata; in_tag = tag; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        if (op[1]) ref_mem[a] = sdata;
        else begin
            exp_data_q.push_back(ref_mem[a]);
            exp_tag_q.push_back(tag);
            exp_req_q.push_back(req);
        end
        @(posedge clk);
        @(negedge clk);
        if (op[1]) check(!out_valid, "R8 store gave result", {31'b0, out_valid}, 0);
        else check(out_valid && out_tag == tag, "R7 load timing/tag",
                   {26'b0, out_valid, out_tag}, {26'b0, 1'b1, tag});
        in_valid = 1'b0;
    endtask

    // Monitor: compare each taken result against the queue head.
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", out_data, 0);
            end else begin
                logic [DW-1:0] ed;
                logic [TW-1:0] et;
                string er;
                ed = exp_data_q.pop_front();
                et = exp_tag_q.pop_front();
                er = exp_req_q.pop_front();
                check(out_data == ed && out_tag == et, er, out_data, ed);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R10 reset state", {30'b0, out_valid, in_ready}, 1);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R10 after reset", {30'b0, out_valid, in_ready}, 1);

        // R3/R4 stores, then R1/R2 loads, plus cross-mode reads (R5: no scaling)
        issue(2'b10, 32'd100, 16'd5, 32'd0, 32'hA5A5_0001, 5'd1, "R3");
        issue(2'b11, 32'd200, 16'd0, 32'd7, 32'hB6B6_0002, 5'd2, "R4");
        issue(2'b00, 32'd100, 16'd5, 32'd0, 32'd0, 5'd3, "R1 R3 load imm");
        issue(2'b01, 32'd200, 16'd0, 32'd7, 32'd0, 5'd4, "R2 R4 load reg");
        issue(2'b01, 32'd100, 16'd0, 32'd5, 32'd0, 5'd5, "R5 reg reads imm store");
        issue(2'b00, 32'd206, 16'd1, 32'd0, 32'd0, 5'd6, "R5 imm reads reg store");

        // R6: negative immediate
        issue(2'b10, 32'd300, 16'hFFFC, 32'd0, 32'hC0DE_0003, 5'd7, "R6");
        issue(2'b01, 32'd290, 16'd0, 32'd6, 32'd0, 5'd8, "R6 negative imm");
        issue(2'b00, 32'd0, 16'hFFFF, 32'd0, 32'd0, 5'd9, "R6 R5 wrap to 1023");

        // R5: alias above bit 9
        issue(2'b10, 32'h0000_040C, 16'd0, 32'd0, 32'hD00D_0004, 5'd10, "R5");
        issue(2'b00, 32'd12, 16'd0, 32'd0, 32'd0, 5'd11, "R5 alias low");
        issue(2'b01, 32'hFFFF_FFFF, 16'd0, 32'd13, 32'd0, 5'd12, "R5 alias wrap");
        issue(2'b11, 32'd1023, 16'd0, 32'd1023, 32'hE1E1_0005, 5'd13, "R4");
        issue(2'b01, 32'd0, 16'd0, 32'd1022, 32'd0, 5'd14, "R4 R5 reg store wrap");

        // R9: stall with a store held at the input
        issue(2'b10, 32'd50, 16'd0, 32'd0, 32'h1111_1111, 5'd15, "R3");
        out_ready = 1'b0;
        issue(2'b00, 32'd100, 16'd5, 32'd0, 32'd0, 5'd16, "R9 stalled load");
        in_op = 2'b10; in_base = 32'd50; in_imm = 16'd0; in_sdata = 32'h2222_2222;
        in_tag = 5'd17; in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            check(!in_ready, "R9 ready low", {31'b0, in_ready}, 0);
            check(out_valid && out_data == 32'hA5A5_0001 && out_tag == 5'd16,
                  "R9 result held", out_data, 32'hA5A5_0001);
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        issue(2'b00, 32'd50, 16'd0, 32'd0, 32'd0, 5'd18, "R9 blocked store ignored");
        @(negedge clk);
        @(negedge clk);
        check(exp_data_q.size() == 0, "R7 results outstanding", exp_data_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule